// File: doc/BRIEF.md
# Serial Audio Bit-Clock and Frame-Sync Generator

This block produces the timing skeleton of a two-channel serial audio port: a bit clock, a frame-sync signal and a pair of single-cycle enables that tell a data shifter when to launch and when to sample each bit. The bit clock comes either from an internal divider running off the system clock or from an external clock pin, which is resynchronised into the system domain. Frame length and sync pulse width are programmed in bit-clock units, each written as its value minus one, so fields of 31 and 15 give the common 32-bit stereo frame with a sync that covers one 16-bit channel.

Two enables bring the block out of idle in order: the generator enable starts the bit clock, and the frame-sync enable, set after it, lets frames run. Frames are issued back to back in periodic mode, or one per transfer request in on-demand mode. A one-cycle frame-start strobe marks the bit counter wrapping to zero. All configuration inputs are expected to be static while the enables are set.

Top module: `frame_clock_gen`

## Requirements
- R1: While rst_n is low, and in the cycle after it, fsync sits at its inactive level (0 when fs_invert is 0), and bclk, frame_start, launch_tick and sample_tick are 0.
- R2: With ext_clk_sel = 0 and gen_run = 1, bclk is the system clock divided by 2*(div_half_m1+1): it stays high for div_half_m1+1 cycles and low for div_half_m1+1 cycles.
- R3: frame_start pulses repeat every (frame_len_m1+1) bit clocks in periodic mode, and bit_pos never exceeds frame_len_m1.
- R4: fsync is active from the frame_start cycle for (sync_len_m1+1) bit clocks, when sync_len_m1 <= frame_len_m1.
- R5: With fs_invert = 0 fsync is active high; with fs_invert = 1 it is active low, and its idle level is 1.
- R6: frame_start is high for exactly one system cycle, and bit_pos is 0 in that cycle.
- R7: While gen_run = 0, bclk stays 0 and no launch_tick, sample_tick or frame_start occurs.
- R8: With gen_run = 1 and fs_run = 0 the bit clock still runs but fsync stays inactive and no frame starts; clearing fs_run mid-frame sets fsync inactive and bit_pos to 0 in the next cycle.
- R9: With ext_clk_sel = 1 the bit clock follows ext_bclk through a two-stage synchroniser, and frame length and sync width are counted in ext_bclk periods.
- R10: With periodic = 0 no frame starts without a request; one xfer_req pulse produces exactly one frame.
- R11: Fields frame_len_m1 = 31 and sync_len_m1 = 15 give a 32-bit frame whose sync is active for 16 bit clocks.
- R12: sample_tick marks each bclk rise and launch_tick each bclk fall, one system cycle each, never both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_run | input | 1 | Releases the bit-clock generator |
| fs_run | input | 1 | Releases frame-sync output (set after gen_run) |
| ext_clk_sel | input | 1 | 1 = bit clock from ext_bclk, 0 = internal divider |
| ext_bclk | input | 1 | External bit-clock pin |
| div_half_m1 | input | DIV_W | Internal bclk half period in system cycles, minus one |
| frame_len_m1 | input | PER_W | Bits per frame minus one |
| sync_len_m1 | input | PER_W | Frame-sync active width in bits, minus one |
| fs_invert | input | 1 | 1 = active-low frame sync |
| periodic | input | 1 | 1 = back-to-back frames, 0 = one frame per request |
| xfer_req | input | 1 | Transfer request pulse for on-demand mode |
| bclk | output | 1 | Bit clock (system-domain level) |
| fsync | output | 1 | Frame sync |
| frame_start | output | 1 | One-cycle strobe at each frame start |
| launch_tick | output | 1 | Enable at each bclk fall, for the transmit shifter |
| sample_tick | output | 1 | Enable at each bclk rise, for the receive shifter |
| bit_pos | output | PER_W | Bit index within the current frame |

## Verification
The hardest state to reach is the release ordering: a frame already in flight when fs_run drops, with the bit clock still running underneath. The bench enables both controls, waits for a frame to start and a few bits to pass, then clears fs_run alone and inspects fsync and bit_pos on the following cycle. External clocking is reached by toggling ext_bclk from the bench on a fixed cycle count, so the synchroniser delay is constant and frame spacing can be measured exactly.

// File: rtl/fsg_pkg.sv
// Shared types for the frame clock generator.
// Assumes: nothing beyond IEEE 1800-2017.
package fsg_pkg;
    // Pair of one-cycle enables marking bit-clock edges.
    typedef struct packed {
        logic rise;
        logic fall;
    } bit_edge_t;
endpackage

// File: rtl/fsg_clk_div.sv
// Internal bit-clock divider: toggles bclk every (half_m1+1) system cycles,
// giving a 50% duty clock of period 2*(half_m1+1), and flags each edge.
// Assumes: half_m1 static while en is high.
module fsg_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [DIV_W-1:0]      half_m1,
    output logic                  bclk,
    output fsg_pkg::bit_edge_t    edges
);
    logic [DIV_W-1:0] cnt;

    // Half-period counter with clock toggle and edge flags.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt   <= '0;
            bclk  <= 1'b0;
            edges <= '0;
        end else begin
            edges <= '0;
            if (cnt == half_m1) begin
                cnt        <= '0;
                bclk       <= ~bclk;
                edges.rise <= ~bclk;
                edges.fall <= bclk;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsg_ext_sync.sv
// External bit-clock capture: resynchronises the pin through STAGES flops
// and flags its rising and falling edges in the system domain.
// Assumes: pin period of at least four system cycles.
module fsg_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  pin,
    output logic                  lvl,
    output fsg_pkg::bit_edge_t    edges
);
    logic [STAGES:0] chain;

    // First capture flop of the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pin;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        // Remaining synchroniser and history flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
        end
    end

    // Edge flags from the synchronised level and its history.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            edges <= '0;
        end else begin
            edges.rise <= chain[STAGES-1] & ~chain[STAGES];
            edges.fall <= ~chain[STAGES-1] & chain[STAGES];
        end
    end

    assign lvl = en & chain[STAGES];
endmodule

// File: rtl/fsg_frame_ctr.sv
// Frame sequencer: counts bits on each sample edge, wraps after
// (len_m1+1) bits, drives frame sync for (wid_m1+1) bits from each start.
// Assumes: configuration static while run is high.
module fsg_frame_ctr #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             periodic,
    input  logic             req,
    input  logic [PER_W-1:0] len_m1,
    input  logic [PER_W-1:0] wid_m1,
    input  logic             invert,
    output logic             fsync,
    output logic             start,
    output logic [PER_W-1:0] pos
);
    logic in_frame;
    logic pend;

    // Bit counter, frame state, pending request and start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            in_frame <= 1'b0;
            pos      <= '0;
            start    <= 1'b0;
            pend     <= 1'b0;
        end else begin
            start <= 1'b0;
            if (req) pend <= 1'b1;
            if (tick) begin
                if (in_frame && pos != len_m1) begin
                    pos <= pos + 1'b1;
                end else if (periodic || pend || req) begin
                    in_frame <= 1'b1;
                    pos      <= '0;
                    start    <= 1'b1;
                    pend     <= 1'b0;
                end else begin
                    in_frame <= 1'b0;
                    pos      <= '0;
                end
            end
        end
    end

    assign fsync = (in_frame && pos <= wid_m1) ^ invert;
endmodule

// File: rtl/frame_clock_gen.sv
// Bit-clock and frame-sync generator for a two-channel serial port.
// Selects internal divider or external pin as bit-clock source and
// sequences frames on the selected clock's rising edges.
// Assumes: configuration inputs static while gen_run is high.
module frame_clock_gen #(
    parameter int DIV_W       = 8,
    parameter int PER_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_run,
    input  logic             fs_run,
    input  logic             ext_clk_sel,
    input  logic             ext_bclk,
    input  logic [DIV_W-1:0] div_half_m1,
    input  logic [PER_W-1:0] frame_len_m1,
    input  logic [PER_W-1:0] sync_len_m1,
    input  logic             fs_invert,
    input  logic             periodic,
    input  logic             xfer_req,
    output logic             bclk,
    output logic             fsync,
    output logic             frame_start,
    output logic             launch_tick,
    output logic             sample_tick,
    output logic [PER_W-1:0] bit_pos
);
    import fsg_pkg::*;

    logic      int_bclk, ext_lvl;
    bit_edge_t int_edges, ext_edges, sel_edges;

    fsg_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(gen_run & ~ext_clk_sel),
        .half_m1(div_half_m1), .bclk(int_bclk), .edges(int_edges)
    );

    fsg_ext_sync #(.STAGES(SYNC_STAGES)) u_ext (
        .clk(clk), .rst_n(rst_n), .en(gen_run & ext_clk_sel),
        .pin(ext_bclk), .lvl(ext_lvl), .edges(ext_edges)
    );

    // Clock source selection.
    always_comb begin
        sel_edges = ext_clk_sel ? ext_edges : int_edges;
        bclk      = ext_clk_sel ? ext_lvl : int_bclk;
    end

    assign sample_tick = sel_edges.rise;
    assign launch_tick = sel_edges.fall;

    fsg_frame_ctr #(.PER_W(PER_W)) u_frm (
        .clk(clk), .rst_n(rst_n), .run(gen_run & fs_run),
        .tick(sel_edges.rise), .periodic(periodic), .req(xfer_req),
        .len_m1(frame_len_m1), .wid_m1(sync_len_m1), .invert(fs_invert),
        .fsync(fsync), .start(frame_start), .pos(bit_pos)
    );
endmodule

// File: rtl/frame_clock_gen_chk.sv
// Property checker for frame_clock_gen, bound to every instance.
module frame_clock_gen_chk #(
    parameter int PER_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gen_run,
    input logic             fs_run,
    input logic             fs_invert,
    input logic [PER_W-1:0] frame_len_m1,
    input logic             bclk,
    input logic             fsync,
    input logic             frame_start,
    input logic             launch_tick,
    input logic             sample_tick,
    input logic [PER_W-1:0] bit_pos
);
    assert_pos_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_pos <= frame_len_m1);

    assert_start_pos_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> bit_pos == '0);

    assert_start_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    assert_sync_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> fsync != fs_invert);

    assert_gen_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_run |=> (!sample_tick && !launch_tick && !frame_start && !bclk));

    assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_run && !fs_run) |=> (fsync == fs_invert && bit_pos == '0));

    assert_tick_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_tick && launch_tick));

    assert_sample_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |=> !sample_tick);
endmodule

bind frame_clock_gen frame_clock_gen_chk #(.PER_W(PER_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .gen_run(gen_run), .fs_run(fs_run),
    .fs_invert(fs_invert), .frame_len_m1(frame_len_m1), .bclk(bclk),
    .fsync(fsync), .frame_start(frame_start), .launch_tick(launch_tick),
    .sample_tick(sample_tick), .bit_pos(bit_pos)
);

// File: tb/sim_frame_clock_gen.sv
module sim_frame_clock_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gen_run = 1'b0, fs_run = 1'b0, ext_clk_sel = 1'b0, ext_bclk = 1'b0;
    logic [7:0] div_half_m1 = 8'd1, frame_len_m1 = 8'd7, sync_len_m1 = 8'd2;
    logic       fs_invert = 1'b0, periodic = 1'b1, xfer_req = 1'b0;
    logic       bclk, fsync, frame_start, launch_tick, sample_tick;
    logic [7:0] bit_pos;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    frame_clock_gen u0 (
        .clk(clk), .rst_n(rst_n), .gen_run(gen_run), .fs_run(fs_run),
        .ext_clk_sel(ext_clk_sel), .ext_bclk(ext_bclk), .div_half_m1(div_half_m1),
        .frame_len_m1(frame_len_m1), .sync_len_m1(sync_len_m1), .fs_invert(fs_invert),
        .periodic(periodic), .xfer_req(xfer_req), .bclk(bclk), .fsync(fsync),
        .frame_start(frame_start), .launch_tick(launch_tick),
        .sample_tick(sample_tick), .bit_pos(bit_pos)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_all();
        @(negedge clk);
        gen_run = 0; fs_run = 0; ext_clk_sel = 0; ext_bclk = 0; xfer_req = 0;
        periodic = 1; fs_invert = 0;
        repeat (3) @(negedge clk);
    endtask

    // Waits for a frame start, then measures cycles to the next one and
    // the number of cycles with fsync active in between.
    task automatic measure(input string req, output int per, output int act);
        int t = 0;
        per = 0; act = 0;
        while (!frame_start && t < 2000) begin @(negedge clk); t++; end
        chk(bit_pos == 0, "R6", bit_pos, 0);
        do begin
            if (fsync != fs_invert) act++;
            per++;
            @(negedge clk);
            if (per == 1) chk(!frame_start, "R6", frame_start, 0);
        end while (!frame_start && per < 2000);
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        chk(fsync == 0 && bclk == 0 && frame_start == 0 && !launch_tick && !sample_tick,
            "R1", {fsync, bclk, frame_start, launch_tick, sample_tick}, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(fsync == 0 && bclk == 0 && frame_start == 0, "R1",
            {fsync, bclk, frame_start}, 0);
    endtask

    task automatic t_int_clock();
        int hi = 0, lo = 0, t = 0;
        div_half_m1 = 8'd2; gen_run = 1;
        while (!(bclk == 1) && t < 100) begin @(negedge clk); t++; end
        while (bclk == 1 && hi < 100) begin hi++; @(negedge clk); end
        while (bclk == 0 && lo < 100) begin lo++; @(negedge clk); end
        chk(hi == 3, "R2 high", hi, 3);
        chk(lo == 3, "R2 low", lo, 3);
        idle_all();
    endtask

    task automatic t_ticks();
        int r = 0, f = 0, both = 0, rise_ok = 1;
        logic prev = 0;
        div_half_m1 = 8'd1; gen_run = 1;
        repeat (4) @(negedge clk);
        prev = bclk;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (sample_tick) r++;
            if (launch_tick) f++;
            if (sample_tick && launch_tick) both++;
            if (sample_tick && !(bclk && !prev)) rise_ok = 0;
            prev = bclk;
        end
        chk(r == 16, "R12 sample count", r, 16);
        chk(f == 16, "R12 launch count", f, 16);
        chk(both == 0 && rise_ok == 1, "R12 edges", both, 0);
        idle_all();
    endtask

    task automatic t_basic();
        int per, act;
        div_half_m1 = 8'd1; frame_len_m1 = 8'd7; sync_len_m1 = 8'd2;
        gen_run = 1; @(negedge clk); fs_run = 1;
        measure("R3", per, act);
        chk(per == 32, "R3 period", per, 32);
        chk(act == 12, "R4 width", act, 12);
        idle_all();
    endtask

    task automatic t_default();
        int per, act;
        div_half_m1 = 8'd0; frame_len_m1 = 8'd31; sync_len_m1 = 8'd15;
        gen_run = 1; @(negedge clk); fs_run = 1;
        measure("R11", per, act);
        chk(per == 64, "R11 period", per, 64);
        chk(act == 32, "R11 width", act, 32);
        idle_all();
    endtask

    task automatic t_polarity();
        int per, act;
        fs_invert = 1; div_half_m1 = 8'd1; frame_len_m1 = 8'd7; sync_len_m1 = 8'd2;
        repeat (2) @(negedge clk);
        chk(fsync == 1, "R5 idle high", fsync, 1);
        gen_run = 1; @(negedge clk); fs_run = 1;
        measure("R5", per, act);
        chk(act == 12, "R5 low width", act, 12);
        idle_all();
    endtask

    task automatic t_gen_off();
        int bad = 0;
        fs_run = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (bclk || sample_tick || launch_tick || frame_start) bad++;
        end
        chk(bad == 0, "R7", bad, 0);
        idle_all();
    endtask

    task automatic t_release();
        int rises = 0, bad = 0, t = 0;
        div_half_m1 = 8'd1; frame_len_m1 = 8'd7; sync_len_m1 = 8'd2;
        gen_run = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sample_tick) rises++;
            if (fsync != 0 || frame_start) bad++;
        end
        chk(rises == 10, "R8 clock runs", rises, 10);
        chk(bad == 0, "R8 no frame", bad, 0);
        fs_run = 1;
        while (!frame_start && t < 200) begin @(negedge clk); t++; end
        repeat (14) @(negedge clk);
        chk(bit_pos != 0, "R8 mid-frame", bit_pos, 3);
        fs_run = 0;
        @(negedge clk);
        chk(fsync == 0 && bit_pos == 0, "R8 clear", {fsync, bit_pos}, 0);
        idle_all();
    endtask

    task automatic t_external();
        int st[3];
        int n = 0, act = 0;
        frame_len_m1 = 8'd3; sync_len_m1 = 8'd1; div_half_m1 = 8'd0;
        ext_clk_sel = 1; gen_run = 1; @(negedge clk); fs_run = 1;
        for (int i = 0; i < 400 && n < 3; i++) begin
            @(negedge clk);
            if (i % 5 == 0) ext_bclk = ~ext_bclk;
            if (frame_start) begin st[n] = i; n++; end
            if (n == 2 && fsync) act++;
        end
        chk(n == 3, "R9 frames", n, 3);
        chk(st[2] - st[1] == 40, "R9 period", st[2] - st[1], 40);
        chk(act == 20, "R9 width", act, 20);
        idle_all();
    endtask

    task automatic t_on_demand();
        int n = 0;
        periodic = 0; div_half_m1 = 8'd1; frame_len_m1 = 8'd7; sync_len_m1 = 8'd2;
        gen_run = 1; @(negedge clk); fs_run = 1;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (frame_start) n++; end
        chk(n == 0, "R10 no request", n, 0);
        xfer_req = 1; @(negedge clk); xfer_req = 0;
        n = 0;
        for (int i = 0; i < 200; i++) begin @(negedge clk); if (frame_start) n++; end
        chk(n == 1, "R10 one frame", n, 1);
        chk(fsync == 0, "R10 idle after", fsync, 0);
        idle_all();
    endtask

    initial begin
        while (cycles < 150000) begin @(posedge clk); cycles++; end
        failures++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_int_clock();
        t_ticks();
        t_basic();
        t_default();
        t_polarity();
        t_gen_off();
        t_release();
        t_external();
        t_on_demand();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule